// File: doc/BRIEF.md
# Speculative Load Violation Detector

This block keeps track of loads that have been allowed to read the cache before the memory ordering rules permit it. Their values have already been handed to dependent instructions. Each tracked load keeps its cache line address and its instruction tag. The entry stays live until the older long-latency access that the load was ordered behind completes. At that point the pipeline retires the entry, and the load counts as legal.

While an entry is live, the detector compares it against every coherence invalidation and every cache eviction. A line that is invalidated or evicted while a speculative read of it is outstanding may have changed underneath the load. The detector does not read the cache a second time and compare the value. Instead it treats any such event as a mis-speculation, even when the cause is false sharing or a write of the same value. It then pulses a squash request that names the oldest affected load. The pipeline discards that load and everything younger, and re-executes the load. In the same clock edge the detector drops the affected entry and every younger entry. When the table is full, a new speculative load is refused and has to wait until it becomes legal.

Top module: `spec_load_guard`

## Requirements
- R1: After reset the table is empty: `alloc_ready` is 1 and `squash_valid` is 0.
- R2: A load presented on `alloc_valid` is accepted while fewer than DEPTH entries are live. With DEPTH entries live, `alloc_ready` is 0, and a load presented then is not tracked: an invalidation of its line raises no squash.
- R3: An invalidation whose line equals a live entry's line raises `squash_valid` for exactly one cycle, one clock after the invalidation. The pulse carries that entry's tag and line, with `squash_cause` = 0.
- R4: An eviction whose line equals a live entry's line raises the same kind of squash, with `squash_cause` = 1. When an invalidation and an eviction both hit the reported entry in the same cycle, the cause is 0.
- R5: When several live entries are hit in one cycle, by either event kind, the squash names the entry that was allocated earliest. This holds after the circular storage has wrapped.
- R6: A squash removes the named entry and all entries allocated after it. Entries allocated before it stay live and can still be hit.
- R7: A `retire_valid` pulse removes the oldest live entry, after which its line no longer causes a squash. A retire pulse with no live entry has no effect.
- R8: Invalidations and evictions of lines held by no live entry raise no squash.
- R9: When a retire arrives in the same cycle as a hit on the oldest entry, the hit wins: the squash names that entry.
- R10: A load accepted in a cycle where an invalidation or eviction matches its own line is squashed, provided no older entry is hit. A load presented in any cycle that raises a squash is not tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | A speculative load was performed and needs tracking |
| alloc_line | input | LINE_W | Line address of that load |
| alloc_id | input | ID_W | Instruction tag of that load |
| alloc_ready | output | 1 | Table has a free entry |
| retire_valid | input | 1 | Oldest tracked load became legal |
| inv_valid | input | 1 | Coherence invalidation observed |
| inv_line | input | LINE_W | Line being invalidated |
| evict_valid | input | 1 | Cache eviction observed |
| evict_line | input | LINE_W | Line being evicted |
| squash_valid | output | 1 | One-cycle squash-and-retry request |
| squash_id | output | ID_W | Tag of the oldest violating load |
| squash_line | output | LINE_W | Line of that load |
| squash_cause | output | 1 | 0 invalidation, 1 eviction |

## Verification
On every cycle, the assertions check the invariants of the table. Occupancy never exceeds the depth. A write never lands on a live slot. The selected victim really is one of the hit entries. A squash never appears without a snoop or eviction in the cycle before it, and a squash never grows the table. A retire on an empty table leaves it empty. Which tag is reported, the clearing of younger entries while older ones survive, and the same-cycle corner cases can only be shown by the bench's directed scenarios. Those corner cases are retire against a hit on the oldest entry, and allocation against a matching snoop. The same holds for the survival of an entry across pointer wrap.

// File: rtl/slg_pkg.sv
package slg_pkg;
  typedef enum logic {
    CAUSE_INV   = 1'b0,
    CAUSE_EVICT = 1'b1
  } cause_e;
endpackage

// File: rtl/slg_entry_store.sv
module slg_entry_store #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26,
  parameter int ID_W   = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PTR_W-1:0]  head_idx,
  input  logic [PTR_W:0]    count,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [ID_W-1:0]   wr_id,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  input  logic              evict_valid,
  input  logic [LINE_W-1:0] evict_line,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  output logic [ID_W-1:0]   rd_id,
  output logic [DEPTH-1:0]  live,
  output logic [DEPTH-1:0]  inv_hit,
  output logic [DEPTH-1:0]  evict_hit
);
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [ID_W-1:0]   id_q   [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [PTR_W-1:0] age_off;
    assign age_off = PTR_W'(i) - head_idx;
    assign live[i] = {1'b0, age_off} < count;

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == PTR_W'(i)) begin
        line_q[i] <= wr_line;
        id_q[i]   <= wr_id;
      end
    end

    assign inv_hit[i]   = live[i] && inv_valid   && (line_q[i] == inv_line);
    assign evict_hit[i] = live[i] && evict_valid && (line_q[i] == evict_line);
  end

  assign rd_line = line_q[rd_idx];
  assign rd_id   = id_q[rd_idx];

  AST_WRITE_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !live[wr_idx]); // R2
endmodule

// File: rtl/slg_age_pick.sv
module slg_age_pick #(
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] hit,
  input  logic [PTR_W-1:0] head_idx,
  output logic             found,
  output logic [PTR_W-1:0] pick_idx,
  output logic [PTR_W-1:0] pick_off
);
  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    pick_off = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (hit[head_idx + PTR_W'(k)]) begin
        found    = 1'b1;
        pick_idx = head_idx + PTR_W'(k);
        pick_off = PTR_W'(k);
      end
    end
  end

  AST_PICK_IS_HIT: assert property (@(posedge clk) disable iff (rst)
    found |-> hit[pick_idx]); // R5
  AST_PICK_FOUND: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |-> found); // R5
endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26,
  parameter int ID_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic [ID_W-1:0]   alloc_id,
  output logic              alloc_ready,
  input  logic              retire_valid,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  input  logic              evict_valid,
  input  logic [LINE_W-1:0] evict_line,
  output logic              squash_valid,
  output logic [ID_W-1:0]   squash_id,
  output logic [LINE_W-1:0] squash_line,
  output logic              squash_cause
);
  import slg_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(DEPTH);

  initial begin
    if (DEPTH < 2 || (1 << PTR_W) != DEPTH)
      $error("DEPTH must be a power of two of at least 2");
  end

  logic [PTR_W:0]    head_q, tail_q, cnt;
  logic [DEPTH-1:0]  live, inv_hit, evict_hit, any_hit;
  logic              found;
  logic [PTR_W-1:0]  pick_idx, pick_off;
  logic [LINE_W-1:0] rd_line;
  logic [ID_W-1:0]   rd_id;
  logic              take_alloc, in_inv, in_evict, in_hit, viol;
  logic              wr_en, retire_fire;

  logic              sq_valid_q;
  logic [ID_W-1:0]   sq_id_q;
  logic [LINE_W-1:0] sq_line_q;
  cause_e            sq_cause_q;

  assign cnt         = tail_q - head_q;
  assign alloc_ready = (cnt != FULL_CNT);

  slg_entry_store #(.DEPTH(DEPTH), .LINE_W(LINE_W), .ID_W(ID_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .head_idx   (head_q[PTR_W-1:0]),
    .count      (cnt),
    .wr_en      (wr_en),
    .wr_idx     (tail_q[PTR_W-1:0]),
    .wr_line    (alloc_line),
    .wr_id      (alloc_id),
    .inv_valid  (inv_valid),
    .inv_line   (inv_line),
    .evict_valid(evict_valid),
    .evict_line (evict_line),
    .rd_idx     (pick_idx),
    .rd_line    (rd_line),
    .rd_id      (rd_id),
    .live       (live),
    .inv_hit    (inv_hit),
    .evict_hit  (evict_hit)
  );

  assign any_hit = inv_hit | evict_hit;

  slg_age_pick #(.DEPTH(DEPTH)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .hit     (any_hit),
    .head_idx(head_q[PTR_W-1:0]),
    .found   (found),
    .pick_idx(pick_idx),
    .pick_off(pick_off)
  );

  // the incoming load is youngest, so it only counts when nothing older is hit
  assign take_alloc  = alloc_valid && alloc_ready;
  assign in_inv      = take_alloc && inv_valid   && (inv_line   == alloc_line);
  assign in_evict    = take_alloc && evict_valid && (evict_line == alloc_line);
  assign in_hit      = in_inv || in_evict;
  assign viol        = found || in_hit;
  assign wr_en       = take_alloc && !viol;
  assign retire_fire = retire_valid && (cnt != '0) && !(found && pick_off == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (retire_fire) head_q <= head_q + 1'b1;
      if (found)       tail_q <= head_q + {1'b0, pick_off};
      else if (wr_en)  tail_q <= tail_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_valid_q <= 1'b0;
      sq_id_q    <= '0;
      sq_line_q  <= '0;
      sq_cause_q <= CAUSE_INV;
    end else begin
      sq_valid_q <= viol;
      if (found) begin
        sq_id_q    <= rd_id;
        sq_line_q  <= rd_line;
        sq_cause_q <= inv_hit[pick_idx] ? CAUSE_INV : CAUSE_EVICT;
      end else if (in_hit) begin
        sq_id_q    <= alloc_id;
        sq_line_q  <= alloc_line;
        sq_cause_q <= in_inv ? CAUSE_INV : CAUSE_EVICT;
      end
    end
  end

  assign squash_valid = sq_valid_q;
  assign squash_id    = sq_id_q;
  assign squash_line  = sq_line_q;
  assign squash_cause = sq_cause_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT); // R2
  AST_SQUASH_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    !(inv_valid || evict_valid) |=> !squash_valid); // R8
  AST_SQUASH_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    found |=> cnt <= $past(cnt)); // R6
  AST_RETIRE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) && !alloc_valid |=> cnt == '0); // R7
  AST_HEAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (found && pick_off == '0) |=> $stable(head_q)); // R9
endmodule

// File: tb/sim_spec_load_guard.sv
module sim_spec_load_guard;
  localparam int DEPTH  = 8;
  localparam int LINE_W = 26;
  localparam int ID_W   = 6;

  logic              clk = 1'b0;
  logic              rst;
  logic              alloc_valid, retire_valid, inv_valid, evict_valid;
  logic [LINE_W-1:0] alloc_line, inv_line, evict_line;
  logic [ID_W-1:0]   alloc_id;
  logic              alloc_ready, squash_valid, squash_cause;
  logic [ID_W-1:0]   squash_id;
  logic [LINE_W-1:0] squash_line;

  int n_vec  = 0;
  int n_miss = 0;

  always #5 clk = ~clk;

  spec_load_guard #(.DEPTH(DEPTH), .LINE_W(LINE_W), .ID_W(ID_W)) u0 (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_line(alloc_line), .alloc_id(alloc_id),
    .alloc_ready(alloc_ready), .retire_valid(retire_valid),
    .inv_valid(inv_valid), .inv_line(inv_line),
    .evict_valid(evict_valid), .evict_line(evict_line),
    .squash_valid(squash_valid), .squash_id(squash_id),
    .squash_line(squash_line), .squash_cause(squash_cause)
  );

  task automatic clear_inputs();
    alloc_valid = 0; alloc_line = '0; alloc_id = '0; retire_valid = 0;
    inv_valid = 0; inv_line = '0; evict_valid = 0; evict_line = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; clear_inputs();
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  // drive one cycle of stimulus; outputs of that edge are visible on return
  task automatic drive(input logic av, input logic [LINE_W-1:0] al, input logic [ID_W-1:0] aid,
                       input logic rv, input logic iv, input logic [LINE_W-1:0] il,
                       input logic ev, input logic [LINE_W-1:0] el);
    alloc_valid = av; alloc_line = al; alloc_id = aid; retire_valid = rv;
    inv_valid = iv; inv_line = il; evict_valid = ev; evict_line = el;
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic alloc(input logic [LINE_W-1:0] l, input logic [ID_W-1:0] id);
    drive(1, l, id, 0, 0, '0, 0, '0);
  endtask
  task automatic inv(input logic [LINE_W-1:0] l);
    drive(0, '0, '0, 0, 1, l, 0, '0);
  endtask
  task automatic retire();
    drive(0, '0, '0, 1, 0, '0, 0, '0);
  endtask

  task automatic chk_none(input string req);
    n_vec++;
    if (squash_valid !== 1'b0) begin
      n_miss++;
      $display("FAIL %s squash_valid got %b exp 0", req, squash_valid);
    end
  endtask

  task automatic chk_sq(input string req, input logic [ID_W-1:0] id,
                        input logic [LINE_W-1:0] line, input logic cause);
    n_vec++;
    if (squash_valid !== 1'b1 || squash_id !== id || squash_line !== line || squash_cause !== cause) begin
      n_miss++;
      $display("FAIL %s got v=%b id=%0d line=%h cause=%b exp v=1 id=%0d line=%h cause=%b",
               req, squash_valid, squash_id, squash_line, squash_cause, id, line, cause);
    end
  endtask

  task automatic chk_rdy(input string req, input logic exp);
    n_vec++;
    if (alloc_ready !== exp) begin
      n_miss++;
      $display("FAIL %s alloc_ready got %b exp %b", req, alloc_ready, exp);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk_rdy("R1", 1'b1);
    chk_none("R1");
  endtask

  task automatic t_fill_and_retire();
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      alloc(26'h100 + LINE_W'(i), ID_W'(i));
      chk_rdy("R2", i < DEPTH - 1);
    end
    alloc(26'h200, 6'd40);          // refused while full
    inv(26'h200);
    chk_none("R2 refused load untracked");
    for (int i = 0; i < DEPTH; i++) retire();
    chk_rdy("R7", 1'b1);
    inv(26'h100);
    chk_none("R7 retired line");
    retire();                        // empty: no effect
    alloc(26'h55, 6'd3);
    inv(26'h55);
    chk_sq("R7 retire on empty ignored", 6'd3, 26'h55, 1'b0);
  endtask

  task automatic t_inv_hit();
    do_reset();
    alloc(26'hA, 6'd1); alloc(26'hB, 6'd2); alloc(26'hC, 6'd3);
    inv(26'h77);
    chk_none("R8 unrelated line");
    inv(26'hB);
    chk_sq("R3", 6'd2, 26'hB, 1'b0);
    @(negedge clk);
    chk_none("R3 single pulse");
    inv(26'hC);
    chk_none("R6 younger cleared");
    inv(26'hA);
    chk_sq("R6 older kept", 6'd1, 26'hA, 1'b0);
  endtask

  task automatic t_evict();
    do_reset();
    alloc(26'h30, 6'd5); alloc(26'h31, 6'd6);
    drive(0, '0, '0, 0, 0, '0, 1, 26'h31);
    chk_sq("R4", 6'd6, 26'h31, 1'b1);
    drive(0, '0, '0, 0, 1, 26'h30, 1, 26'h30);
    chk_sq("R4 both events", 6'd5, 26'h30, 1'b0);
  endtask

  task automatic t_oldest();
    do_reset();
    alloc(26'h40, 6'd10); alloc(26'h41, 6'd11); alloc(26'h40, 6'd12);
    inv(26'h40);
    chk_sq("R5 same line", 6'd10, 26'h40, 1'b0);
    inv(26'h41);
    chk_none("R6 all younger cleared");
    alloc(26'h50, 6'd20); alloc(26'h51, 6'd21);
    drive(0, '0, '0, 0, 1, 26'h51, 1, 26'h50);
    chk_sq("R5 mixed events", 6'd20, 26'h50, 1'b1);
  endtask

  task automatic t_retire_vs_hit();
    do_reset();
    alloc(26'h60, 6'd1); alloc(26'h61, 6'd2);
    drive(0, '0, '0, 1, 1, 26'h60, 0, '0);
    chk_sq("R9", 6'd1, 26'h60, 1'b0);
    alloc(26'h62, 6'd3); alloc(26'h63, 6'd4);
    drive(0, '0, '0, 1, 1, 26'h63, 0, '0);
    chk_sq("R9 retire of other entry", 6'd4, 26'h63, 1'b0);
    inv(26'h62);
    chk_none("R7 head retired alongside squash");
  endtask

  task automatic t_alloc_vs_snoop();
    do_reset();
    drive(1, 26'h70, 6'd7, 0, 1, 26'h70, 0, '0);
    chk_sq("R10 own line", 6'd7, 26'h70, 1'b0);
    inv(26'h70);
    chk_none("R10 not tracked");
    alloc(26'h71, 6'd8);
    drive(1, 26'h72, 6'd9, 0, 1, 26'h71, 0, '0);
    chk_sq("R10 older wins", 6'd8, 26'h71, 1'b0);
    inv(26'h72);
    chk_none("R10 dropped in squash cycle");
  endtask

  task automatic t_wrap();
    do_reset();
    for (int i = 0; i < 6; i++) alloc(26'h300 + LINE_W'(i), ID_W'(i));
    for (int i = 0; i < 5; i++) retire();
    for (int i = 0; i < 5; i++) alloc(26'h305, ID_W'(30 + i));
    alloc(26'h399, 6'd50); alloc(26'h39A, 6'd51);
    chk_rdy("R2 full after wrap", 1'b0);
    inv(26'h305);
    chk_sq("R5 across wrap", 6'd5, 26'h305, 1'b0);
    chk_rdy("R6 table emptied", 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    rst = 1;
    clear_inputs();
    t_reset();
    t_fill_and_retire();
    t_inv_hit();
    t_evict();
    t_oldest();
    t_retire_vs_hit();
    t_alloc_vs_snoop();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule